// File: doc/BRIEF.md
# Forward-Frame Transmit Sequencer

This block sends forward frames on the control-device side of a two-wire lighting bus that uses Manchester coding. Software writes the bytes of a frame one after another. The first byte is the address and the rest are data. Each byte goes through a one-byte staging register into a shift register. The shift register turns each bit into two half-bit levels, and it advances on a half-bit clock-enable pulse. A byte written while the shift register is free and no inter-frame gap is running moves into the shift register at once. This leaves the staging register free for the next byte.

When the shift register runs empty and no byte is staged, the frame has ended. The line then stays high for the configured number of stop bits, followed by a software-set number of half-bit periods. Bytes written during that gap wait in the staging register. A backward frame seen on the bus delays the next frame. When the backward frame completes, the gap timer restarts. The block also offers a flush of all pending bytes, and it keeps sticky flags for "byte taken", "frame ended" and "collision".

Top module: `fwd_frame_tx`

## Requirements
- R1: After a synchronous reset, `tx_line` is 1, all three flags are 0 and `buf_empty` is 1.
- R2: If a byte is written while no frame is being shifted, no gap is running, `rx_busy` and `rx_done` are low and nothing is staged, it enters the shift register on that clock edge and `rdy_flag` sets. A second byte written while that byte is still shifting stays staged and does not set `rdy_flag`.
- R3: Each bit is sent as two half-bit periods, most significant bit first. The first half carries the inverse of the bit and the second half carries the bit (1 = low then high). Each level appears on the clock edge that samples a `half_tick` pulse, and `tx_line` changes at no other time while a frame is sent.
- R4: When the last half of a byte is sent and a byte is staged, the staged byte moves into the shift register on that same edge. Its first half follows on the next tick with no idle period, and `rdy_flag` sets.
- R5: When the last half of a byte is sent and nothing is staged, `end_flag` sets. The line is then high for 2*(`stop_sel`+1) half-bit ticks, followed by `gap_len` more ticks.
- R6: A byte written during the stop or gap period stays staged (`buf_empty` = 0, line high). Its first half-bit appears on tick 2*(`stop_sel`+1)+`gap_len`+1, counted from the tick after the previous frame's last half.
- R7: While `rx_busy` is high, no frame starts. A `rx_done` pulse outside a frame reloads the gap counter, so a staged byte's first half appears on tick `gap_len`+1 after the pulse.
- R8: A `flush` pulse empties both registers. It sets `buf_empty`, aborts a frame in progress and drives `tx_line` high on the same edge. No more half-bits are sent, and a write in the same cycle as `flush` is discarded.
- R9: `coll_flag` sets if `rx_busy` is high while a frame is being shifted, or on any `rx_bit_err` pulse. A backward frame (`rx_busy`, `rx_done`) outside a frame leaves `coll_flag` at 0.
- R10: Each flag stays set until its clear input is pulsed. If a set and a clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| half_tick | input | 1 | One-cycle pulse per half-bit period |
| stop_sel | input | 2 | Stop bits minus one |
| gap_len | input | 16 | Inter-frame wait in half-bit periods |
| wr_en | input | 1 | Write strobe for a frame byte |
| wr_byte | input | 8 | Byte to send |
| flush | input | 1 | Discard all pending bytes |
| rx_busy | input | 1 | A backward frame is being received |
| rx_done | input | 1 | Pulse: backward frame stop bits received |
| rx_bit_err | input | 1 | Pulse: received bit lacked its mid-bit edge |
| clr_rdy | input | 1 | Clear `rdy_flag` |
| clr_end | input | 1 | Clear `end_flag` |
| clr_coll | input | 1 | Clear `coll_flag` |
| tx_line | output | 1 | Manchester-coded bus output, idle high |
| rdy_flag | output | 1 | Sticky: a byte entered the shift register |
| end_flag | output | 1 | Sticky: frame ended |
| coll_flag | output | 1 | Sticky: collision or bit error |
| buf_empty | output | 1 | High when no byte is staged or shifting |

## Verification
The assertions rely on the following about the inputs:
- `half_tick` comes from a separate rate generator.
- `rx_busy` and `rx_done` follow a backward-frame decoder: `rx_done` arrives after `rx_busy` drops.
- `stop_sel` and `gap_len` stay constant while a gap is counting.

The stimulus follows these rules:
- `half_tick` is a one-cycle pulse followed by one quiet cycle.
- `flush`, `rx_done` and `rx_bit_err` are single-cycle pulses.
- The stop and gap settings change only when the block is idle or has just been flushed.

The bench sweeps every stop-bit setting against gap lengths 0 to 3. It computes each expected idle length and Manchester sequence arithmetically.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_SEND = 2'd1,
      SQ_STOP = 2'd2,
      SQ_WAIT = 2'd3
   } sq_state_e;
endpackage

// File: rtl/fts_hold.sv
`timescale 1ns/1ps
module fts_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              hold_v,
   output logic [DATA_W-1:0] hold_d
);
   // take with an empty stage means the write bypassed straight to the shifter
   always_ff @(posedge clk) begin
      if (rst || flush) begin
         hold_v <= 1'b0;
         hold_d <= '0;
      end else if (take && hold_v) begin
         hold_v <= wr_en;
         if (wr_en) hold_d <= wr_data;
      end else if (wr_en && !take) begin
         hold_v <= 1'b1;
         hold_d <= wr_data;
      end
   end
endmodule

// File: rtl/fts_shift.sv
`timescale 1ns/1ps
module fts_shift #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              abort,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              step,
   output logic              half_lvl,
   output logic              last_half,
   output logic              tsr_v
);
   localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

   logic [DATA_W-1:0] tsr;
   logic [IDX_W-1:0]  idx;
   logic              ph;
   logic              cur_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         assign cur_bit = tsr[TOP_IDX - idx];
      end else begin : g_lsb
         assign cur_bit = tsr[idx];
      end
   endgenerate

   assign half_lvl  = ph ? cur_bit : ~cur_bit;
   assign last_half = ph && (idx == TOP_IDX);

   always_ff @(posedge clk) begin
      if (rst || abort) begin
         tsr   <= '0;
         idx   <= '0;
         ph    <= 1'b0;
         tsr_v <= 1'b0;
      end else if (load) begin
         tsr   <= load_data;
         idx   <= '0;
         ph    <= 1'b0;
         tsr_v <= 1'b1;
      end else if (step) begin
         if (last_half) begin
            tsr_v <= 1'b0;
         end else begin
            ph <= ~ph;
            if (ph) idx <= idx + 1'b1;
         end
      end
   end

   AST_STEP_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
      step |-> tsr_v);  // R3
endmodule

// File: rtl/fts_seq.sv
`timescale 1ns/1ps
module fts_seq
   import fts_pkg::*;
#(
   parameter int WAIT_W = 16,
   parameter int STOP_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              half_tick,
   input  logic [STOP_W-1:0] stop_sel,
   input  logic [WAIT_W-1:0] gap_len,
   input  logic              flush,
   input  logic              rx_busy,
   input  logic              rx_done,
   input  logic              wr_en,
   input  logic              hold_v,
   input  logic              tsr_v,
   input  logic              half_lvl,
   input  logic              last_half,
   output sq_state_e         state,
   output logic              load,
   output logic              step,
   output logic              frame_end,
   output logic              tx_line
);
   localparam int CNT_W = (WAIT_W > STOP_W + 2) ? WAIT_W : STOP_W + 2;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] stop_len;
   logic [CNT_W-1:0] gap_ext;
   logic             gap_nz;
   logic             have_data;
   logic             can_start;

   assign stop_len  = CNT_W'((32'(stop_sel) + 32'd1) * 32'd2);
   assign gap_ext   = CNT_W'(gap_len);
   assign gap_nz    = (gap_len != '0);
   assign have_data = hold_v || wr_en;
   assign can_start = (state == SQ_IDLE) && !rx_busy && !rx_done;
   assign step      = (state == SQ_SEND) && half_tick && !flush;
   assign load      = !flush && have_data && (can_start || (step && last_half));
   assign frame_end = step && last_half && !have_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= SQ_IDLE;
         cnt     <= '0;
         tx_line <= 1'b1;
      end else if (flush && state == SQ_SEND) begin
         state   <= SQ_IDLE;
         tx_line <= 1'b1;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (rx_done) begin
                  state <= gap_nz ? SQ_WAIT : SQ_IDLE;
                  cnt   <= gap_ext;
               end else if (load) begin
                  state <= SQ_SEND;
               end
            end
            SQ_SEND: begin
               if (half_tick) begin
                  tx_line <= half_lvl;
                  if (last_half && !load) begin
                     state <= SQ_STOP;
                     cnt   <= stop_len;
                  end
               end
            end
            SQ_STOP: begin
               if (rx_done) begin
                  tx_line <= 1'b1;
                  state   <= gap_nz ? SQ_WAIT : SQ_IDLE;
                  cnt     <= gap_ext;
               end else if (half_tick) begin
                  tx_line <= 1'b1;
                  if (cnt == CNT_W'(1)) begin
                     state <= gap_nz ? SQ_WAIT : SQ_IDLE;
                     cnt   <= gap_ext;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
            end
            SQ_WAIT: begin
               if (rx_done) begin
                  state <= gap_nz ? SQ_WAIT : SQ_IDLE;
                  cnt   <= gap_ext;
               end else if (half_tick) begin
                  if (cnt == CNT_W'(1)) state <= SQ_IDLE;
                  else                  cnt   <= cnt - 1'b1;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   AST_SEND_OWNS_BYTE: assert property (@(posedge clk) disable iff (rst)
      (state == SQ_SEND) |-> tsr_v);  // R2
   AST_LINE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      (!half_tick && !flush && !rx_done) |=> $stable(tx_line));  // R3
   AST_WAIT_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
      (state == SQ_WAIT) |-> tx_line);  // R5
   AST_GAP_NO_START: assert property (@(posedge clk) disable iff (rst)
      (state == SQ_STOP || state == SQ_WAIT) |=> (state != SQ_SEND));  // R6
endmodule

// File: rtl/fts_flags.sv
`timescale 1ns/1ps
module fts_flags #(
   parameter int NFLAG = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NFLAG-1:0] set_i,
   input  logic [NFLAG-1:0] clr_i,
   output logic [NFLAG-1:0] flag_o
);
   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (rst)           flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (clr_i[i]) flag_o[i] <= 1'b0;
         end

         AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            (flag_o[i] && !clr_i[i]) |=> flag_o[i]);  // R10
      end
   endgenerate
endmodule

// File: rtl/fwd_frame_tx.sv
`timescale 1ns/1ps
module fwd_frame_tx
   import fts_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int WAIT_W    = 16,
   parameter int STOP_W    = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              half_tick,
   input  logic [STOP_W-1:0] stop_sel,
   input  logic [WAIT_W-1:0] gap_len,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              flush,
   input  logic              rx_busy,
   input  logic              rx_done,
   input  logic              rx_bit_err,
   input  logic              clr_rdy,
   input  logic              clr_end,
   input  logic              clr_coll,
   output logic              tx_line,
   output logic              rdy_flag,
   output logic              end_flag,
   output logic              coll_flag,
   output logic              buf_empty
);
   localparam int NFLAG = 3;

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (WAIT_W < 1 || STOP_W < 1) begin : g_bad_cnt
         $error("WAIT_W and STOP_W must be at least 1");
      end
   endgenerate

   sq_state_e         state;
   logic              load, step, frame_end;
   logic              hold_v, tsr_v, half_lvl, last_half;
   logic [DATA_W-1:0] hold_d, load_data;
   logic [NFLAG-1:0]  fl_set, fl_clr, fl_q;

   assign load_data = hold_v ? hold_d : wr_byte;

   fts_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .wr_data(wr_byte),
      .take(load), .hold_v(hold_v), .hold_d(hold_d)
   );

   fts_shift #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst(rst), .abort(flush), .load(load), .load_data(load_data),
      .step(step), .half_lvl(half_lvl), .last_half(last_half), .tsr_v(tsr_v)
   );

   fts_seq #(.WAIT_W(WAIT_W), .STOP_W(STOP_W)) u_seq (
      .clk(clk), .rst(rst), .half_tick(half_tick), .stop_sel(stop_sel),
      .gap_len(gap_len), .flush(flush), .rx_busy(rx_busy), .rx_done(rx_done),
      .wr_en(wr_en), .hold_v(hold_v), .tsr_v(tsr_v), .half_lvl(half_lvl),
      .last_half(last_half), .state(state), .load(load), .step(step),
      .frame_end(frame_end), .tx_line(tx_line)
   );

   assign fl_set = {rx_bit_err || (rx_busy && state == SQ_SEND), frame_end, load};
   assign fl_clr = {clr_coll, clr_end, clr_rdy};

   fts_flags #(.NFLAG(NFLAG)) u_flags (
      .clk(clk), .rst(rst), .set_i(fl_set), .clr_i(fl_clr), .flag_o(fl_q)
   );

   assign rdy_flag  = fl_q[0];
   assign end_flag  = fl_q[1];
   assign coll_flag = fl_q[2];
   assign buf_empty = !hold_v && !tsr_v;

   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
      flush |=> (buf_empty && tx_line));  // R8
   AST_ERR_SETS_COLL: assert property (@(posedge clk) disable iff (rst)
      rx_bit_err |=> coll_flag);  // R9
endmodule

// File: tb/fwd_frame_tx_test.sv
`timescale 1ns/1ps
module fwd_frame_tx_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       half_tick = 0, wr_en = 0, flush = 0;
   logic       rx_busy = 0, rx_done = 0, rx_bit_err = 0;
   logic       clr_rdy = 0, clr_end = 0, clr_coll = 0;
   logic [1:0] stop_sel = 2'd1;
   logic [15:0] gap_len = 16'd0;
   logic [7:0] wr_byte = 8'h00;
   logic       tx_line, rdy_flag, end_flag, coll_flag, buf_empty;
   int         checks = 0;
   int         errors = 0;
   logic       smp;

   always #4 clk = ~clk;

   fwd_frame_tx uut (
      .clk(clk), .rst(rst), .half_tick(half_tick), .stop_sel(stop_sel),
      .gap_len(gap_len), .wr_en(wr_en), .wr_byte(wr_byte), .flush(flush),
      .rx_busy(rx_busy), .rx_done(rx_done), .rx_bit_err(rx_bit_err),
      .clr_rdy(clr_rdy), .clr_end(clr_end), .clr_coll(clr_coll),
      .tx_line(tx_line), .rdy_flag(rdy_flag), .end_flag(end_flag),
      .coll_flag(coll_flag), .buf_empty(buf_empty)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic tick(output logic lvl);
      half_tick = 1'b1;
      @(negedge clk);
      half_tick = 1'b0;
      lvl = tx_line;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] b);
      wr_en = 1'b1; wr_byte = b;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_flush();
      flush = 1'b1; @(negedge clk); flush = 1'b0;
   endtask

   function automatic logic man_half(input logic [7:0] b, input int k);
      logic bit_v;
      bit_v = b[7 - k / 2];
      return (k % 2 == 1) ? bit_v : ~bit_v;
   endfunction

   task automatic send_check(input logic [7:0] b, input string tag);
      int bad;
      bad = 0;
      for (int k = 0; k < 16; k++) begin
         tick(smp);
         if (smp != man_half(b, k)) bad++;
      end
      check(tag, bad, 0);
   endtask

   task automatic count_gap(output int n);
      n = 0;
      tick(smp);
      while (smp == 1'b1 && n < 60) begin
         n++;
         tick(smp);
      end
   endtask

   initial begin
      #(8 * 200000);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      cyc(); cyc(); cyc();
      rst = 1'b0;
      cyc();
      // R1 reset state
      check("R1 line", tx_line, 1);
      check("R1 flags", {rdy_flag, end_flag, coll_flag}, 0);
      check("R1 buf_empty", buf_empty, 1);

      // R2 direct load, R3 encoding, R4 boundary transfer
      wr(8'hA5);
      check("R2 rdy on direct load", rdy_flag, 1);
      check("R2 buf_empty", buf_empty, 0);
      clr_rdy = 1'b1; cyc(); clr_rdy = 1'b0;
      check("R10 clear rdy", rdy_flag, 0);
      wr(8'h3C);
      check("R2 staged write no rdy", rdy_flag, 0);
      for (int k = 0; k < 15; k++) tick(smp);
      check("R4 rdy before boundary", rdy_flag, 0);
      tick(smp);
      check("R3 last half of A5", smp, int'(man_half(8'hA5, 15)));
      check("R4 rdy at boundary", rdy_flag, 1);
      send_check(8'h3C, "R4 R3 second byte continuous");
      check("R5 end flag", end_flag, 1);
      check("R5 buf_empty after frame", buf_empty, 1);
      n = 0;
      for (int k = 0; k < 4; k++) begin tick(smp); n += int'(smp); end
      check("R5 stop idle high", n, 4);

      // R5 R6 sweep of stop bits and gap length
      for (int s = 0; s < 4; s++) begin
         for (int w = 0; w < 4; w++) begin
            stop_sel = 2'(s); gap_len = 16'(w);
            clr_end = 1'b1; cyc(); clr_end = 1'b0;
            wr(8'h80);
            for (int k = 0; k < 16; k++) tick(smp);
            check("R5 end flag sweep", end_flag, 1);
            wr(8'h80);
            check("R6 byte held in gap", buf_empty, 0);
            count_gap(n);
            check("R6 R5 gap length", n, 2 * (s + 1) + w);
            pulse_flush();
         end
      end

      // R7 backward frame restarts the wait
      stop_sel = 2'd0; gap_len = 16'd6;
      clr_coll = 1'b1; cyc(); clr_coll = 1'b0;
      wr(8'h80);
      for (int k = 0; k < 16; k++) tick(smp);
      wr(8'h80);
      for (int k = 0; k < 5; k++) tick(smp);
      rx_busy = 1'b1; cyc(); cyc(); cyc(); rx_busy = 1'b0;
      rx_done = 1'b1; cyc(); rx_done = 1'b0;
      check("R9 backward frame outside send no collision", coll_flag, 0);
      count_gap(n);
      check("R7 wait restarted", n, 6);
      pulse_flush();

      // R7 busy receiver blocks start
      gap_len = 16'd0;
      rx_busy = 1'b1;
      wr(8'h80);
      n = 0;
      for (int k = 0; k < 4; k++) begin tick(smp); n += int'(smp); end
      check("R7 no start while busy", n, 4);
      check("R7 byte kept while busy", buf_empty, 0);
      rx_busy = 1'b0;
      cyc();
      tick(smp);
      check("R7 start after busy", smp, 0);
      check("R9 no collision when not overlapping", coll_flag, 0);

      // R9 collision while sending
      rx_busy = 1'b1; cyc(); rx_busy = 1'b0;
      check("R9 overlap collision", coll_flag, 1);
      clr_coll = 1'b1; cyc(); clr_coll = 1'b0;
      check("R10 clear coll", coll_flag, 0);
      rx_bit_err = 1'b1; cyc(); rx_bit_err = 1'b0;
      check("R9 bit error", coll_flag, 1);
      clr_coll = 1'b1; cyc(); clr_coll = 1'b0;
      rx_bit_err = 1'b1; clr_coll = 1'b1; cyc();
      rx_bit_err = 1'b0; clr_coll = 1'b0;
      check("R10 set beats clear", coll_flag, 1);
      pulse_flush();

      // R8 flush mid-frame
      wr(8'h11);
      wr(8'h22);
      clr_rdy = 1'b1; cyc(); clr_rdy = 1'b0;
      tick(smp); tick(smp);
      check("R3 second half of 0x11 bit7", smp, 0);
      pulse_flush();
      check("R8 buf_empty", buf_empty, 1);
      check("R8 line high", tx_line, 1);
      n = 0;
      for (int k = 0; k < 6; k++) begin tick(smp); n += int'(smp); end
      check("R8 no half-bits after flush", n, 6);
      check("R8 no transfer after flush", rdy_flag, 0);
      flush = 1'b1; wr_en = 1'b1; wr_byte = 8'h80; cyc();
      flush = 1'b0; wr_en = 1'b0;
      check("R8 write beside flush dropped", buf_empty, 1);
      tick(smp);
      check("R8 line idle after dropped write", smp, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule